// File: doc/BRIEF.md
# Processor General Register Bank with Hard-Wired Zero Entry

This block holds the integer working registers of a small load/store processor: 32 entries of 32 bits each. Two read ports serve the two source operands of an instruction in the same cycle. One write port takes the destination result.

Both read ports are purely combinational: an index goes in and the entry's contents come out in the same cycle. The write port commits on the rising clock edge, and only while its enable is high. Entry 0 is wired to the constant zero. A write aimed at it is accepted on the interface but nothing is stored, so instructions can use index 0 as a zero source or as a discard destination. The highest entry is ordinary storage, which lets call logic place a return link there. A synchronous reset clears every entry.

Top module: `gpr_bank`

## Requirements
- R1: While the reset input is high at a rising clock edge, every entry is cleared to zero at that edge, and any write presented in the same cycle is ignored. Afterwards every index reads 0 on both ports.
- R2: When the write enable is high at a rising clock edge, the entry chosen by the 5-bit write index (1 to 31) takes the write data. Both read ports return that value from the cycle after the edge.
- R3: When the write enable is low at a rising clock edge, no entry changes, whatever the write index and write data are.
- R4: A read of index 0 returns 0x00000000 on either port at all times, including after writes that target index 0.
- R5: A write aimed at index 0 leaves every other entry unchanged.
- R6: The two read ports work independently in the same cycle. When both select the same index, both return the same value.
- R7: A read of an entry that is being written in the current cycle returns the entry's old contents until the rising edge. The new value appears only after that edge.
- R8: Index 31 is written and read back like any other non-zero entry.
- R9: A write changes only the addressed entry. All other non-zero entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Index selecting the entry for read port A |
| rd_a_data | output | 32 | Contents of the entry selected on port A |
| rd_b_idx | input | 5 | Index selecting the entry for read port B |
| rd_b_data | output | 32 | Contents of the entry selected on port B |
| wr_en | input | 1 | Write enable for the write port |
| wr_idx | input | 5 | Destination index of the write port |
| wr_data | input | 32 | Value to store at the destination |

## Verification
Every stored bit is visible on the read ports in the same cycle it is addressed, so a corrupt entry shows up on the first read of that index after the faulty edge. The exception is a fault in the stored copy of entry 0, which the read path masks by design. A write-select decode that goes to the wrong entry, or that fires when the enable is low, shows up as a changed neighbour only when that neighbour is read. For this reason the bench sweeps every index on both ports after it fills the bank with distinct values. A missing zero rule shows at once as a non-zero read of index 0 after a write to it.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    // Default geometry of the general register bank
    localparam int GPR_ENTRIES = 32;
    localparam int GPR_WIDTH   = 32;

    // Width of an index that covers a given number of entries
    function automatic int idx_bits(input int entries);
        return (entries > 1) ? $clog2(entries) : 1;
    endfunction
endpackage

// File: rtl/gpr_wr_decode.sv
// Turns the write port into one strobe per entry; entry 0 never gets one.
module gpr_wr_decode #(
    parameter int ENTRIES = gpr_pkg::GPR_ENTRIES,
    parameter int IW      = gpr_pkg::idx_bits(ENTRIES)
) (
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    output logic [ENTRIES-1:0] wr_sel
);
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_sel
            if (g == 0) begin : g_zero
                assign wr_sel[g] = 1'b0;
            end else begin : g_norm
                assign wr_sel[g] = wr_en && (wr_idx == IW'(g));
            end
        end
    endgenerate
endmodule

// File: rtl/gpr_read_mux.sv
// One combinational read port; index 0 is forced to zero on the way out.
module gpr_read_mux #(
    parameter int ENTRIES = gpr_pkg::GPR_ENTRIES,
    parameter int WIDTH   = gpr_pkg::GPR_WIDTH,
    parameter int IW      = gpr_pkg::idx_bits(ENTRIES)
) (
    input  logic [ENTRIES-1:0][WIDTH-1:0] regs,
    input  logic [IW-1:0]                 rd_idx,
    output logic [WIDTH-1:0]              rd_data
);
    always_comb begin
        if (rd_idx == '0) begin
            rd_data = '0;
        end else begin
            rd_data = regs[rd_idx];
        end
    end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
    parameter int ENTRIES = gpr_pkg::GPR_ENTRIES,
    parameter int WIDTH   = gpr_pkg::GPR_WIDTH,
    localparam int IW     = gpr_pkg::idx_bits(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IW-1:0]    rd_a_idx,
    output logic [WIDTH-1:0] rd_a_data,
    input  logic [IW-1:0]    rd_b_idx,
    output logic [WIDTH-1:0] rd_b_data,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data
);
    typedef struct packed {
        logic [ENTRIES-1:0][WIDTH-1:0] regs;
    } bank_state_t;

    bank_state_t         state_d, state_q;
    logic [ENTRIES-1:0]  wr_sel;

    gpr_wr_decode #(.ENTRIES(ENTRIES), .IW(IW)) wdec_i (
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_sel (wr_sel)
    );

    // Next-state: reset wins, then per-entry strobes load the write data
    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.regs = '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_sel[i]) begin
                    state_d.regs[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    gpr_read_mux #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IW(IW)) rd_a_i (
        .regs    (state_q.regs),
        .rd_idx  (rd_a_idx),
        .rd_data (rd_a_data)
    );

    gpr_read_mux #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IW(IW)) rd_b_i (
        .regs    (state_q.regs),
        .rd_idx  (rd_b_idx),
        .rd_data (rd_b_data)
    );
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
    parameter int ENTRIES = gpr_pkg::GPR_ENTRIES,
    parameter int WIDTH   = gpr_pkg::GPR_WIDTH,
    parameter int IW      = gpr_pkg::idx_bits(ENTRIES)
) (
    input logic             clk,
    input logic             rst,
    input logic [IW-1:0]    rd_a_idx,
    input logic [WIDTH-1:0] rd_a_data,
    input logic [IW-1:0]    rd_b_idx,
    input logic [WIDTH-1:0] rd_b_data,
    input logic             wr_en,
    input logic [IW-1:0]    wr_idx,
    input logic [WIDTH-1:0] wr_data
);
    // R4
    zero_read_a_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> (rd_a_data == '0));

    // R4
    zero_read_b_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx == '0) |-> (rd_b_data == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

    // R2
    write_visible_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en) && $past(wr_idx) != '0 && rd_a_idx == $past(wr_idx))
        |-> (rd_a_data == $past(wr_data)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(wr_en) && $stable(rd_b_idx)) |-> $stable(rd_b_data));

    // R6
    same_index_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));
endmodule

bind gpr_bank gpr_bank_chk #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IW(IW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
);

// File: tb/gpr_bank_tb_top.sv
`timescale 1ns/1ps
module gpr_bank_tb_top;
    localparam int W  = 32;
    localparam int IW = 5;
    localparam int NV = 10;

    typedef struct packed {
        logic          we;
        logic [IW-1:0] widx;
        logic [W-1:0]  wdat;
        logic [IW-1:0] ra;
        logic [IW-1:0] rb;
        logic [W-1:0]  exp_a;
        logic [W-1:0]  exp_b;
        logic [7:0]    req;
    } vec_t;

    // Reads are checked before the edge that commits the row's write
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd5,  32'hAAAA_0005, 5'd5,  5'd0,  32'h0000_0000, 32'h0000_0000, 8'd7}, // R7
        '{1'b1, 5'd31, 32'h8000_0031, 5'd5,  5'd31, 32'hAAAA_0005, 32'h0000_0000, 8'd2}, // R2
        '{1'b0, 5'd5,  32'hFFFF_FFFF, 5'd5,  5'd31, 32'hAAAA_0005, 32'h8000_0031, 8'd8}, // R8
        '{1'b1, 5'd0,  32'hDEAD_BEEF, 5'd0,  5'd5,  32'h0000_0000, 32'hAAAA_0005, 8'd3}, // R3
        '{1'b0, 5'd0,  32'h0000_0000, 5'd0,  5'd5,  32'h0000_0000, 32'hAAAA_0005, 8'd5}, // R5
        '{1'b1, 5'd6,  32'h1234_5678, 5'd31, 5'd31, 32'h8000_0031, 32'h8000_0031, 8'd6}, // R6
        '{1'b1, 5'd6,  32'h8765_4321, 5'd6,  5'd5,  32'h1234_5678, 32'hAAAA_0005, 8'd7}, // R7
        '{1'b0, 5'd6,  32'h0000_0000, 5'd6,  5'd6,  32'h8765_4321, 32'h8765_4321, 8'd2}, // R2
        '{1'b1, 5'd1,  32'h0000_0001, 5'd1,  5'd2,  32'h0000_0000, 32'h0000_0000, 8'd9}, // R9
        '{1'b0, 5'd0,  32'h0000_0000, 5'd1,  5'd6,  32'h0000_0001, 32'h8765_4321, 8'd9}  // R9
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [IW-1:0] rd_a_idx, rd_b_idx, wr_idx;
    logic [W-1:0]  rd_a_data, rd_b_data, wr_data;
    logic          wr_en;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpr_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .rd_a_idx  (rd_a_idx),
        .rd_a_data (rd_a_data),
        .rd_b_idx  (rd_b_idx),
        .rd_b_data (rd_b_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] fill_val(input int i);
        return (32'h0101_0101 * i) ^ 32'h5A00_00A5;
    endfunction

    // Drive after a falling edge, sample 1 ns later, well before the rising edge
    task automatic drive(input logic we, input logic [IW-1:0] wi, input logic [W-1:0] wd,
                         input logic [IW-1:0] ra, input logic [IW-1:0] rb);
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_data = wd; rd_a_idx = ra; rd_b_idx = rb;
        #1;
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_a_idx = '0; rd_b_idx = '0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: state right after reset
        drive(1'b0, 5'd0, '0, 5'd31, 5'd17);
        check("R1", rd_a_data, 32'h0);
        check("R1", rd_b_data, 32'h0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].we, VECS[v].widx, VECS[v].wdat, VECS[v].ra, VECS[v].rb);
            check($sformatf("R%0d row %0d port A", VECS[v].req, v), rd_a_data, VECS[v].exp_a);
            check($sformatf("R%0d row %0d port B", VECS[v].req, v), rd_b_data, VECS[v].exp_b);
        end

        // R9 / R2: fill every entry with a distinct value, then sweep both ports
        for (int i = 1; i < 32; i++) drive(1'b1, IW'(i), fill_val(i), 5'd0, 5'd0);
        // R3: enable low with every index and a loud data value
        for (int i = 0; i < 32; i++) drive(1'b0, IW'(i), 32'hFFFF_FFFF, 5'd0, 5'd0);
        // R5: write to index 0 after the fill
        drive(1'b1, 5'd0, 32'hC0DE_C0DE, 5'd0, 5'd0);
        for (int i = 0; i < 32; i++) begin
            drive(1'b0, 5'd0, '0, IW'(i), IW'(31 - i));
            check("R9 sweep A", rd_a_data, (i == 0) ? 32'h0 : fill_val(i));
            check("R9 sweep B", rd_b_data, (i == 31) ? 32'h0 : fill_val(31 - i));
        end

        // R8: overwrite index 31 with a link-style value
        drive(1'b1, 5'd31, 32'h0000_3004, 5'd31, 5'd30);
        check("R7 idx31 old", rd_a_data, fill_val(31));
        drive(1'b0, 5'd0, '0, 5'd31, 5'd30);
        check("R8 idx31 new", rd_a_data, 32'h0000_3004);
        check("R9 idx30 kept", rd_b_data, fill_val(30));

        // R1: reset with a concurrent write, then everything reads zero
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_idx = 5'd7; wr_data = 32'h7777_7777;
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < 32; i++) begin
            drive(1'b0, 5'd0, '0, IW'(i), IW'(i));
            check("R1 after reset A", rd_a_data, 32'h0);
            check("R1 after reset B", rd_b_data, 32'h0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule